// File: doc/BRIEF.md
# Mode-dependent stack push unit

This block executes register-push instructions for an 8-bit-bus processor that runs either in a 24-bit address mode or in a 16-bit compatibility mode. It consumes a stream of instruction bytes, one per cycle, while `byte_ready` is high. A push is spelled as an optional size prefix, then either a main-register opcode or an index prefix followed by the index push opcode. Once the block has the opcode, it reads the chosen register through a combinational register-file port. It then writes the value one byte per cycle through a byte-wide memory write port, highest byte first, at descending addresses.

The width of the push and the stack pointer it uses both follow the global `adl_mode` input, and a size prefix can override that choice for one instruction. A long push stores three bytes below the 24-bit long pointer `spl`, which then drops by 3. A short push stores two bytes below the 16-bit short pointer `sps`, which then drops by 2. For a short push the memory address is `mbase` concatenated above the 16-bit result, and the subtraction wraps inside the 64K window. The pointer update, the last write and the one-cycle `done` pulse all fall in the same cycle. No flags exist in this block.

The FSM has four states. ST_IDLE waits for the first byte. ST_PFX is entered after a size prefix. ST_IDX is entered after an index prefix. ST_WR emits the write bytes. The transitions are:
- IDLE→PFX on 0x52 or 0x49.
- IDLE→IDX on 0xDD or 0xFD.
- IDLE→WR on a main push opcode.
- IDLE stays on any other byte.
- PFX→IDX on an index prefix.
- PFX→WR on a main push opcode.
- PFX→IDLE on anything else.
- IDX→WR on 0xE5.
- IDX→IDLE on anything else.
- WR→WR until the last byte is written.
- WR→IDLE on the last byte.

Top module: `push_unit`

## Requirements
- R1: After reset `spl` equals SPL_RESET, `sps` equals SPS_RESET, `mem_we` and `done` are 0, and `byte_ready` is 1.
- R2: A push is long when the byte before the push is the prefix 0x49, or when `adl_mode` is 1 and the prefix 0x52 is absent. In every other case it is short. The prefix sits directly before the main opcode or before the index prefix.
- R3: A long push writes bits 23-16 to `spl`-1, bits 15-8 to `spl`-2 and bits 7-0 to `spl`-3, in that order and one byte per cycle. `spl` then decreases by 3, and `sps` is unchanged.
- R4: A short push writes bits 15-8 to {`mbase`, `sps`-1} and then bits 7-0 to {`mbase`, `sps`-2}. The 16-bit subtraction wraps modulo 65536. `sps` then decreases by 2 with wrap, and `spl` is unchanged.
- R5: A main push opcode has the pattern 11ss0101, and `rf_sel` during its writes equals ss. The register codes are BC=0, DE=1, HL=2 and AF=3.
- R6: The sequence 0xDD 0xE5 pushes IX with `rf_sel`=4, and the sequence 0xFD 0xE5 pushes IY with `rf_sel`=5. Either sequence may follow a size prefix.
- R7: In a long push of AF the top written byte is 0x00, whatever `rf_data[23:16]` holds. In long pushes of the other registers that byte is taken from `rf_data[23:16]`.
- R8: Counting from the cycle the first byte is accepted through the cycle of `done`, the budgets are as follows:
  - Main-register push: 3 cycles short and 4 cycles long.
  - Main-register push with 0x52 in 24-bit mode: 4 cycles.
  - Main-register push with 0x49 in 16-bit mode: 5 cycles.
  - Index push: 4 cycles short and 5 cycles long.
  - Index push with 0x52: 5 cycles.
  - Index push with 0x49: 6 cycles.
  - `byte_ready` is 0 during write cycles, and bytes offered then are not consumed.
- R9: The following bytes are consumed without any write or pointer change, and the block returns to ST_IDLE:
  - A byte in ST_IDLE that is neither a prefix nor a push opcode.
  - A byte after a size prefix that is neither an index prefix nor a main push opcode.
  - A byte other than 0xE5 after an index prefix.
- R10: `done` is high for exactly one cycle, the cycle of the last write. The pointer changes at the clock edge that ends that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| adl_mode | input | 1 | 1 = 24-bit mode, 0 = 16-bit mode |
| mbase | input | 8 | Upper address byte for short-form pushes |
| byte_valid | input | 1 | Instruction byte present |
| byte_in | input | 8 | Instruction byte |
| byte_ready | output | 1 | Block accepts a byte this cycle |
| rf_sel | output | 3 | Register-file select (0 BC, 1 DE, 2 HL, 3 AF, 4 IX, 5 IY) |
| rf_data | input | 24 | Register-file read data for `rf_sel` |
| mem_addr | output | 24 | Write address |
| mem_wdata | output | 8 | Write data |
| mem_we | output | 1 | Write enable, one byte per cycle |
| done | output | 1 | One-cycle pulse on the last write of a push |
| spl | output | 24 | Long stack pointer |
| sps | output | 16 | Short stack pointer |

## Verification
The bench first runs two consecutive short pushes from a short pointer of 3. This forces the low address to wrap from 0x0000 to 0xFFFF. A design that borrowed into `mbase`, or that forgot the wrap, would write the wrong final byte and leave `sps` set to something other than 0xFFFF.

It then runs every prefix and mode combination, checking the form of each push and its cycle count. A wrong override rule would show up as three writes where two were expected, or as the wrong pointer moving. A long push of AF with a nonzero upper register byte must still write 0x00.

Broken sequences are also tried: a prefix followed by junk, an index prefix followed by junk, and stray opcodes. A decoy push opcode is held on the byte input during every write phase. A design that consumed it would start an extra push.

// File: rtl/push_pkg.sv
package push_pkg;
    localparam int BYTE_W  = 8;
    localparam int LONG_W  = 24;
    localparam int SHORT_W = 16;
    localparam int SEL_W   = 3;

    localparam logic [BYTE_W-1:0] CODE_SHORT_PFX = 8'h52;
    localparam logic [BYTE_W-1:0] CODE_LONG_PFX  = 8'h49;
    localparam logic [BYTE_W-1:0] CODE_IX_PFX    = 8'hDD;
    localparam logic [BYTE_W-1:0] CODE_IY_PFX    = 8'hFD;
    localparam logic [BYTE_W-1:0] CODE_IDX_PUSH  = 8'hE5;
    localparam logic [BYTE_W-1:0] MAIN_MASK      = 8'hCF;
    localparam logic [BYTE_W-1:0] MAIN_MATCH     = 8'hC5;

    localparam logic [SEL_W-1:0] SEL_AF = 3'd3;
    localparam logic [SEL_W-1:0] SEL_IX = 3'd4;
    localparam logic [SEL_W-1:0] SEL_IY = 3'd5;

    typedef enum logic [1:0] {ST_IDLE, ST_PFX, ST_IDX, ST_WR} state_t;
    typedef enum logic [1:0] {SZ_NONE, SZ_SHORT, SZ_LONG} size_t;
endpackage

// File: rtl/push_decode.sv
module push_decode
    import push_pkg::*;
(
    input  logic [BYTE_W-1:0] code,
    output logic              pfx_short,
    output logic              pfx_long,
    output logic              pfx_index,
    output logic              is_main,
    output logic              is_index_op,
    output logic [SEL_W-1:0]  main_sel,
    output logic [SEL_W-1:0]  index_sel
);
    assign pfx_short   = (code == CODE_SHORT_PFX);
    assign pfx_long    = (code == CODE_LONG_PFX);
    assign pfx_index   = (code == CODE_IX_PFX) || (code == CODE_IY_PFX);
    assign is_main     = ((code & MAIN_MASK) == MAIN_MATCH);
    assign is_index_op = (code == CODE_IDX_PUSH);
    assign main_sel    = {1'b0, code[5:4]};
    assign index_sel   = (code == CODE_IY_PFX) ? SEL_IY : SEL_IX;
endmodule

// File: rtl/push_sp.sv
module push_sp
    import push_pkg::*;
#(
    parameter logic [23:0] SPL_RESET = 24'hFFFFFF,
    parameter logic [15:0] SPS_RESET = 16'hFFFF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [BYTE_W-1:0]  mbase,
    input  logic               long_sel,
    input  logic [1:0]         k,
    input  logic               commit,
    output logic [LONG_W-1:0]  addr,
    output logic [LONG_W-1:0]  spl,
    output logic [SHORT_W-1:0] sps
);
    localparam logic [LONG_W-1:0]  LONG_STEP  = 24'd3;
    localparam logic [SHORT_W-1:0] SHORT_STEP = 16'd2;

    logic [SHORT_W-1:0] short_lo;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spl <= SPL_RESET;
            sps <= SPS_RESET;
        end else if (commit) begin
            if (long_sel) spl <= spl - LONG_STEP;
            else          sps <= sps - SHORT_STEP;
        end
    end

    always_comb begin
        short_lo = sps - {14'd0, k};
        addr     = long_sel ? (spl - {22'd0, k}) : {mbase, short_lo};
    end

    // R3: the long pointer only ever moves down by three
    a_r3_spl_step: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(spl) |-> (spl == $past(spl) - LONG_STEP));
    // R4: the short pointer only ever moves down by two, with wrap
    a_r4_sps_step: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sps) |-> (sps == $past(sps) - SHORT_STEP));
    // R4: never both pointers in the same cycle
    a_r4_one_pointer: assert property (@(posedge clk) disable iff (!rst_n)
        !(!$stable(spl) && !$stable(sps)));
endmodule

// File: rtl/push_unit.sv
module push_unit
    import push_pkg::*;
#(
    parameter logic [23:0] SPL_RESET = 24'hFFFFFF,
    parameter logic [15:0] SPS_RESET = 16'hFFFF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               adl_mode,
    input  logic [BYTE_W-1:0]  mbase,
    input  logic               byte_valid,
    input  logic [BYTE_W-1:0]  byte_in,
    output logic               byte_ready,
    output logic [SEL_W-1:0]   rf_sel,
    input  logic [LONG_W-1:0]  rf_data,
    output logic [LONG_W-1:0]  mem_addr,
    output logic [BYTE_W-1:0]  mem_wdata,
    output logic               mem_we,
    output logic               done,
    output logic [LONG_W-1:0]  spl,
    output logic [SHORT_W-1:0] sps
);
    state_t             state_q, state_d;
    size_t              size_q, size_d;
    logic [SEL_W-1:0]   sel_q, sel_d;
    logic               long_q, long_d;
    logic [1:0]         cnt_q, cnt_d;

    logic               take, last;
    logic [1:0]         shift;
    logic [LONG_W-1:0]  word;

    logic               pfx_short, pfx_long, pfx_index, is_main, is_index_op;
    logic [SEL_W-1:0]   main_sel, index_sel;

    function automatic logic want_long(input size_t sz, input logic adl);
        return (sz == SZ_LONG) || (adl && (sz != SZ_SHORT));
    endfunction

    push_decode u_dec (
        .code        (byte_in),
        .pfx_short   (pfx_short),
        .pfx_long    (pfx_long),
        .pfx_index   (pfx_index),
        .is_main     (is_main),
        .is_index_op (is_index_op),
        .main_sel    (main_sel),
        .index_sel   (index_sel)
    );

    push_sp #(.SPL_RESET(SPL_RESET), .SPS_RESET(SPS_RESET)) u_sp (
        .clk      (clk),
        .rst_n    (rst_n),
        .mbase    (mbase),
        .long_sel (long_q),
        .k        (cnt_q),
        .commit   (done),
        .addr     (mem_addr),
        .spl      (spl),
        .sps      (sps)
    );

    assign take = byte_valid && byte_ready;
    assign last = (state_q == ST_WR) && (cnt_q == (long_q ? 2'd3 : 2'd2));

    always_comb begin
        state_d = state_q;
        size_d  = size_q;
        sel_d   = sel_q;
        long_d  = long_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: if (take) begin
                if (pfx_short) begin
                    state_d = ST_PFX;
                    size_d  = SZ_SHORT;
                end else if (pfx_long) begin
                    state_d = ST_PFX;
                    size_d  = SZ_LONG;
                end else if (pfx_index) begin
                    state_d = ST_IDX;
                    sel_d   = index_sel;
                end else if (is_main) begin
                    state_d = ST_WR;
                    sel_d   = main_sel;
                    long_d  = want_long(SZ_NONE, adl_mode);
                    cnt_d   = 2'd1;
                end
            end
            ST_PFX: if (take) begin
                if (pfx_index) begin
                    state_d = ST_IDX;
                    sel_d   = index_sel;
                end else if (is_main) begin
                    state_d = ST_WR;
                    sel_d   = main_sel;
                    long_d  = want_long(size_q, adl_mode);
                    cnt_d   = 2'd1;
                end else begin
                    state_d = ST_IDLE;
                    size_d  = SZ_NONE;
                end
            end
            ST_IDX: if (take) begin
                if (is_index_op) begin
                    state_d = ST_WR;
                    long_d  = want_long(size_q, adl_mode);
                    cnt_d   = 2'd1;
                end else begin
                    state_d = ST_IDLE;
                    size_d  = SZ_NONE;
                end
            end
            ST_WR: begin
                if (last) begin
                    state_d = ST_IDLE;
                    size_d  = SZ_NONE;
                end else begin
                    cnt_d = cnt_q + 2'd1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            size_q  <= SZ_NONE;
            sel_q   <= '0;
            long_q  <= 1'b0;
            cnt_q   <= 2'd1;
        end else begin
            state_q <= state_d;
            size_q  <= size_d;
            sel_q   <= sel_d;
            long_q  <= long_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        rf_sel     = sel_q;
        byte_ready = 1'b1;
        mem_we     = 1'b0;
        done       = 1'b0;
        word       = ((sel_q == SEL_AF) && long_q) ? {8'h00, rf_data[15:0]} : rf_data;
        shift      = (long_q ? 2'd3 : 2'd2) - cnt_q;
        unique case (shift)
            2'd0:    mem_wdata = word[7:0];
            2'd1:    mem_wdata = word[15:8];
            default: mem_wdata = word[23:16];
        endcase
        unique case (state_q)
            ST_WR: begin
                byte_ready = 1'b0;
                mem_we     = 1'b1;
                done       = last;
            end
            default: ;
        endcase
    end

    // R8: no byte is fetched while a write is under way
    a_r8_no_fetch_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !byte_ready);
    // R10: done only accompanies a write
    a_r10_done_with_write: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> mem_we);
    // R10: done is a single-cycle pulse
    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R3: back-to-back writes of one push step down by one address
    a_r3_addr_desc: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we) && !$past(done)) |->
        (mem_addr[15:0] == $past(mem_addr[15:0]) - 16'd1));
endmodule

// File: tb/test_push_unit.sv
module test_push_unit;
    localparam logic [23:0] SPL_INIT = 24'h100040;
    localparam logic [15:0] SPS_INIT = 16'h0003;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        adl_mode = 1'b0;
    logic [7:0]  mbase = 8'hA7;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_in = 8'h00;
    logic        byte_ready;
    logic [2:0]  rf_sel;
    logic [23:0] rf_data;
    logic [23:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_we;
    logic        done;
    logic [23:0] spl;
    logic [15:0] sps;

    logic [23:0] regs [0:5];
    logic [23:0] spl_m = SPL_INIT;
    logic [15:0] sps_m = SPS_INIT;
    int          tests = 0;
    int          fails = 0;
    int          ticks = 0;

    always #5 clk = ~clk;

    assign rf_data = (rf_sel < 3'd6) ? regs[rf_sel] : 24'h0;

    push_unit #(.SPL_RESET(SPL_INIT), .SPS_RESET(SPS_INIT)) i_push_unit (
        .clk(clk), .rst_n(rst_n), .adl_mode(adl_mode), .mbase(mbase),
        .byte_valid(byte_valid), .byte_in(byte_in), .byte_ready(byte_ready),
        .rf_sel(rf_sel), .rf_data(rf_data), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_we(mem_we), .done(done),
        .spl(spl), .sps(sps)
    );

    always @(posedge clk) begin
        ticks++;
        if (ticks > 5000) begin
            tests++;
            fails++;
            $display("FAIL R8 watchdog: act %0d exp <5000 cycles", ticks);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: act %0h exp %0h", req, what, act, exp);
        end
    endtask

    // one clock: drive, compare every output, advance the model
    task automatic step(input logic bv, input logic [7:0] b, input logic e_ready,
                        input logic e_we, input logic [23:0] e_addr,
                        input logic [7:0] e_data, input logic [2:0] e_sel,
                        input logic e_done, input logic e_long, input string req);
        byte_valid = bv;
        byte_in    = b;
        #1;
        chk(byte_ready === e_ready, "R8", "byte_ready", byte_ready, e_ready);
        chk(mem_we === e_we, req, "mem_we", mem_we, e_we);
        if (e_we) begin
            chk(mem_addr === e_addr, req, "mem_addr", mem_addr, e_addr);
            chk(mem_wdata === e_data, req, "mem_wdata", mem_wdata, e_data);
            chk(rf_sel === e_sel, req, "rf_sel", rf_sel, e_sel);
        end
        chk(done === e_done, "R10", "done", done, e_done);
        chk(spl === spl_m, req, "spl", spl, spl_m);
        chk(sps === sps_m, req, "sps", sps, sps_m);
        @(posedge clk);
        if (e_done) begin
            if (e_long) spl_m = spl_m - 24'd3;
            else        sps_m = sps_m - 16'd2;
        end
        @(negedge clk);
    endtask

    task automatic idle(input string req);
        step(1'b0, 8'h00, 1'b1, 1'b0, 24'h0, 8'h0, 3'd0, 1'b0, 1'b0, req);
    endtask

    // feed up to three bytes; the model decides whether a push follows
    task automatic run(input int n, input logic [7:0] b0, input logic [7:0] b1,
                       input logic [7:0] b2, input int exp_cyc, input string req);
        logic [7:0]  bs [3];
        int          phase = 0;
        int          sz = 0;
        int          cyc = 0;
        int          sel = 0;
        bit          go = 0;
        bs[0] = b0; bs[1] = b1; bs[2] = b2;
        for (int i = 0; i < n; i++) begin
            logic [7:0] b = bs[i];
            step(1'b1, b, 1'b1, 1'b0, 24'h0, 8'h0, 3'd0, 1'b0, 1'b0, req);
            cyc++;
            go = 0;
            if (phase == 2) begin
                if (b == 8'hE5) go = 1;
                else begin phase = 0; sz = 0; end
            end else begin
                if (phase == 0 && b == 8'h52) begin phase = 1; sz = 1; end
                else if (phase == 0 && b == 8'h49) begin phase = 1; sz = 2; end
                else if (b == 8'hDD) begin phase = 2; sel = 4; end
                else if (b == 8'hFD) begin phase = 2; sel = 5; end
                else if (b[7:6] == 2'b11 && b[3:0] == 4'h5) begin
                    sel = int'(b[5:4]);
                    go = 1;
                end else begin phase = 0; sz = 0; end
            end
            if (go) begin
                bit          lng = (sz == 2) || (adl_mode && sz != 1);
                int          nb = lng ? 3 : 2;
                logic [23:0] v = regs[sel];
                if (sel == 3 && lng) v[23:16] = 8'h00;
                for (int k = 1; k <= nb; k++) begin
                    logic [15:0] lo = sps_m - 16'(k);
                    logic [23:0] a = lng ? (spl_m - 24'(k)) : {mbase, lo};
                    logic [7:0]  d = 8'(v >> (8 * (nb - k)));
                    step(1'b1, 8'hC5, 1'b0, 1'b1, a, d, 3'(sel), k == nb, lng, req);
                    cyc++;
                end
                phase = 0;
                sz = 0;
                chk(cyc == exp_cyc, "R8", "cycle count", cyc, exp_cyc);
            end
        end
        if (exp_cyc == 0)
            chk(phase == 0 && !go, "R9", "sequence abandoned", phase, 0);
        idle(req);
    endtask

    initial begin
        regs[0] = 24'h11B0C0;
        regs[1] = 24'h22D0E0;
        regs[2] = 24'h334455;
        regs[3] = 24'h9A0F5C;
        regs[4] = 24'h6789AB;
        regs[5] = 24'hCDEF01;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        idle("R1");
        // R4 R5: short pushes across the 64K wrap (BC, then DE)
        adl_mode = 1'b0;
        run(1, 8'hC5, 8'h0, 8'h0, 3, "R4");
        run(1, 8'hD5, 8'h0, 8'h0, 3, "R5");
        chk(sps === 16'hFFFF, "R4", "sps wrap", sps, 16'hFFFF);
        // R3: long plain push of HL
        adl_mode = 1'b1;
        run(1, 8'hE5, 8'h0, 8'h0, 4, "R3");
        // R7: long AF with upper byte forced to zero
        run(1, 8'hF5, 8'h0, 8'h0, 4, "R7");
        // R2: short override in 24-bit mode, long override in 16-bit mode
        run(2, 8'h52, 8'hD5, 8'h0, 4, "R2");
        adl_mode = 1'b0;
        run(2, 8'h49, 8'hF5, 8'h0, 5, "R2");
        run(1, 8'hF5, 8'h0, 8'h0, 3, "R5");
        // R6: index pushes in all four forms
        run(2, 8'hDD, 8'hE5, 8'h0, 4, "R6");
        run(3, 8'h49, 8'hFD, 8'hE5, 6, "R6");
        adl_mode = 1'b1;
        run(2, 8'hFD, 8'hE5, 8'h0, 5, "R6");
        run(3, 8'h52, 8'hDD, 8'hE5, 5, "R6");
        // R9: broken sequences leave memory and pointers alone
        run(2, 8'h52, 8'h00, 8'h0, 0, "R9");
        run(2, 8'hDD, 8'h21, 8'h0, 0, "R9");
        run(2, 8'h49, 8'h49, 8'h0, 0, "R9");
        run(1, 8'h3E, 8'h0, 8'h0, 0, "R9");
        // R10: a clean push right after the broken ones
        run(1, 8'hC5, 8'h0, 8'h0, 4, "R10");
        chk(spl === spl_m, "R3", "final spl", spl, spl_m);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule